// File: doc/BRIEF.md
# Prescaled Center-Aligned Timer Counter

This block is a 16-bit timer counter that runs from a programmable prescaler. An enabled cycle advances the prescaler. The counter takes one step each time the prescaler reaches its limit, so it runs at the input clock divided by (prescale value + 1). The counter can count up, count down, or run in one of three center-aligned modes, where it climbs to the reload value and then falls back to zero. The three center-aligned modes differ only in which counting direction lets a compare match raise a channel flag.

There are four compare channels. Each channel drives a PWM reference level, which is high while the count is below the channel's compare value. Each channel also gives a flag pulse when the counter steps onto that compare value in a permitted direction. An update pulse marks each wrap or reversal point. A software strobe restarts the prescaler and the counter at once. A trigger output forwards one of eight internal events or levels, chosen by a select input.

Top module: `ca_timer`

## Requirements
- R1: After the asynchronous reset, cnt_o is 0, dir_o is 0, upd_o is 0 and cmp_flag_o is 0. Mode code 0 selects up counting.
- R2: The counter takes one step per (psc_i + 1) cycles in which en_i is high. When en_i is low, the counter and the prescaler hold their values.
- R3: In mode 0 (up), or in any unused code 5 to 7, a step from a count at or above arr_i loads 0 and pulses upd_o for one cycle. Any other step adds 1. dir_o is 0.
- R4: In mode 1 (down), a step from 0 loads arr_i and pulses upd_o. Any other step subtracts 1. dir_o is 1.
- R5: In center modes 2, 3 and 4, the counter climbs to arr_i with dir_o low. It then reverses and falls with dir_o high, and reverses again at 0. The step that leaves arr_i goes to arr_i-1, and the step that leaves 0 goes to 1; both stay at 0 when arr_i is 0. Each reversal pulses upd_o.
- R6: In mode 2, a channel flag pulses only for a downward step (dir_o becomes 1) that lands on that channel's compare value.
- R7: In mode 3, a channel flag pulses only for an upward step (dir_o becomes 0) that lands on the compare value.
- R8: In mode 4, and in modes 0 and 1, any step that lands on the compare value pulses that channel's flag. The pulse appears in the same cycle as the new count.
- R9: oc_ref_o[k] is 1 exactly while cnt_o < cmp_i[k].
- R10: trg_o follows trg_sel_i. Codes 0 to 3 select ug_i, en_i, upd_o and cmp_flag_o[0]. Codes 4 to 7 select oc_ref_o[0] to oc_ref_o[3].
- R11: ug_i clears the prescaler and the counter, and sets dir_o to 1 in mode 1 and to 0 otherwise. It also pulses upd_o in the next cycle and raises no flag. ug_i wins over a step that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter enable |
| ug_i | input | 1 | Software update-generate strobe |
| psc_i | input | 16 | Prescale value |
| arr_i | input | 16 | Auto-reload value |
| mode_i | input | 3 | Counting mode code |
| cmp_i | input | 4x16 | Compare values, one per channel |
| trg_sel_i | input | 3 | Trigger source select |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | 1 while counting down |
| upd_o | output | 1 | Update pulse |
| oc_ref_o | output | 4 | PWM reference levels |
| cmp_flag_o | output | 4 | Compare flag pulses |
| trg_o | output | 1 | Trigger output |

## Verification
Two functions can fall in the same cycle. A software strobe can arrive in the same cycle as a prescaler tick that would wrap or reverse the counter. Also, a compare value can be set to the reversal point, so that a flag and an update fall together. The stimulus fires the strobe in many positions relative to the tick and sets compare values at 0 and at the reload value. A behavioural model then decides each cycle whether the strobe won, whether a flag was allowed by the direction of the step, and whether the update pulse came from the strobe or from the reversal.

// File: rtl/ca_timer_pkg.sv
package ca_timer_pkg;
  typedef enum logic [2:0] {
    MODE_UP      = 3'd0,
    MODE_DOWN    = 3'd1,
    MODE_CTR_DN  = 3'd2,
    MODE_CTR_UP  = 3'd3,
    MODE_CTR_ALL = 3'd4
  } cnt_mode_e;

  typedef enum logic [2:0] {
    TRG_UG   = 3'd0,
    TRG_EN   = 3'd1,
    TRG_UPD  = 3'd2,
    TRG_FLG0 = 3'd3,
    TRG_REF0 = 3'd4,
    TRG_REF1 = 3'd5,
    TRG_REF2 = 3'd6,
    TRG_REF3 = 3'd7
  } trg_sel_e;

  function automatic logic is_center(logic [2:0] m);
    return (m == MODE_CTR_DN) || (m == MODE_CTR_UP) || (m == MODE_CTR_ALL);
  endfunction
endpackage

// File: rtl/ca_timer_psc.sv
module ca_timer_psc #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ug_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pc_q;

  // >= so a lowered prescale value does not stall the divider
  assign tick_o = en_i && (pc_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (ug_i)   pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else if (en_i)   pc_q <= pc_q + 1'b1;
  end

  // R11
  ug_clears_psc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (pc_q == '0));
endmodule

// File: rtl/ca_timer_cnt.sv
module ca_timer_cnt
  import ca_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ug_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [2:0]       mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             upd_o,
  output logic [CNT_W-1:0] nxt_cnt_o,
  output logic             nxt_dir_o,
  output logic             step_o
);
  logic [CNT_W-1:0] arr_dn, one_or_zero;
  logic             wrap;

  assign arr_dn      = (arr_i == '0) ? '0 : arr_i - 1'b1;
  assign one_or_zero = (arr_i == '0) ? '0 : CNT_W'(1);
  assign step_o      = tick_i && !ug_i;

  always_comb begin
    nxt_cnt_o = cnt_o;
    nxt_dir_o = 1'b0;
    wrap      = 1'b0;
    if (mode_i == MODE_DOWN) begin
      nxt_dir_o = 1'b1;
      if (cnt_o == '0) begin
        nxt_cnt_o = arr_i;
        wrap      = 1'b1;
      end else nxt_cnt_o = cnt_o - 1'b1;
    end else if (is_center(mode_i)) begin
      if (!dir_o) begin
        if (cnt_o >= arr_i) begin
          nxt_cnt_o = arr_dn;
          nxt_dir_o = 1'b1;
          wrap      = 1'b1;
        end else nxt_cnt_o = cnt_o + 1'b1;
      end else begin
        if (cnt_o == '0) begin
          nxt_cnt_o = one_or_zero;
          wrap      = 1'b1;
        end else begin
          nxt_cnt_o = cnt_o - 1'b1;
          nxt_dir_o = 1'b1;
        end
      end
    end else begin
      if (cnt_o >= arr_i) begin
        nxt_cnt_o = '0;
        wrap      = 1'b1;
      end else nxt_cnt_o = cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dir_o <= 1'b0;
      upd_o <= 1'b0;
    end else if (ug_i) begin
      cnt_o <= '0;
      dir_o <= (mode_i == MODE_DOWN);
      upd_o <= 1'b1;
    end else begin
      upd_o <= step_o && wrap;
      if (step_o) begin
        cnt_o <= nxt_cnt_o;
        dir_o <= nxt_dir_o;
      end
    end
  end

  // R2
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ug_i) |=> ($stable(cnt_o) && !upd_o));
  // R3
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && mode_i == MODE_UP && cnt_o >= arr_i) |=> (cnt_o == '0 && upd_o));
  // R4
  down_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && mode_i == MODE_DOWN && cnt_o == '0) |=> (cnt_o == $past(arr_i) && upd_o && dir_o));
  // R11
  ug_clears_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (cnt_o == '0 && upd_o));
endmodule

// File: rtl/ca_timer_cmp.sv
module ca_timer_cmp
  import ca_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       step_i,
  input  logic [2:0]                 mode_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic                       dir_i,
  input  logic [CNT_W-1:0]           nxt_cnt_i,
  input  logic                       nxt_dir_i,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_i,
  output logic [N_CH-1:0]            oc_ref_o,
  output logic [N_CH-1:0]            flag_o
);
  logic allow;

  always_comb begin
    unique case (mode_i)
      MODE_CTR_DN: allow = nxt_dir_i;
      MODE_CTR_UP: allow = !nxt_dir_i;
      default:     allow = 1'b1;
    endcase
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign oc_ref_o[k] = cnt_i < cmp_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[k] <= 1'b0;
      else         flag_o[k] <= step_i && allow && (nxt_cnt_i == cmp_i[k]);
    end

    // R6
    ctr_dn_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_CTR_DN) |=> (!flag_o[k] || dir_i));
    // R7
    ctr_up_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_CTR_UP) |=> (!flag_o[k] || !dir_i));
    // R8
    flag_on_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[k] |-> (cnt_i == $past(cmp_i[k])));
  end
endmodule

// File: rtl/ca_timer.sv
module ca_timer
  import ca_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int N_CH  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       ug_i,
  input  logic [PSC_W-1:0]           psc_i,
  input  logic [CNT_W-1:0]           arr_i,
  input  logic [2:0]                 mode_i,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_i,
  input  logic [2:0]                 trg_sel_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic                       dir_o,
  output logic                       upd_o,
  output logic [N_CH-1:0]            oc_ref_o,
  output logic [N_CH-1:0]            cmp_flag_o,
  output logic                       trg_o
);
  localparam int RefBase = 4;

  logic             tick, step, nxt_dir;
  logic [CNT_W-1:0] nxt_cnt;

  ca_timer_psc #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .en_i, .ug_i, .psc_i, .tick_o(tick)
  );

  ca_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .ug_i, .arr_i, .mode_i,
    .cnt_o, .dir_o, .upd_o, .nxt_cnt_o(nxt_cnt), .nxt_dir_o(nxt_dir), .step_o(step)
  );

  ca_timer_cmp #(.CNT_W(CNT_W), .N_CH(N_CH)) u_cmp (
    .clk_i, .rst_ni, .step_i(step), .mode_i, .cnt_i(cnt_o), .dir_i(dir_o),
    .nxt_cnt_i(nxt_cnt), .nxt_dir_i(nxt_dir), .cmp_i, .oc_ref_o, .flag_o(cmp_flag_o)
  );

  always_comb begin
    unique case (trg_sel_i)
      TRG_UG:   trg_o = ug_i;
      TRG_EN:   trg_o = en_i;
      TRG_UPD:  trg_o = upd_o;
      TRG_FLG0: trg_o = cmp_flag_o[0];
      default: begin
        trg_o = 1'b0;
        for (int k = 0; k < N_CH; k++)
          if (int'(trg_sel_i) == RefBase + k) trg_o = oc_ref_o[k];
      end
    endcase
  end

  // R10
  trg_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trg_sel_i == TRG_UPD) |-> (trg_o == upd_o));
endmodule

// File: tb/ca_timer_tb.sv
module ca_timer_tb;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0, ug = 1'b0;
  logic [15:0]      psc = '0, arr = '0;
  logic [2:0]       mode = '0, tsel = '0;
  logic [3:0][15:0] cmp = '0;
  logic [15:0]      cnt;
  logic             dir, upd, trg;
  logic [3:0]       ref_v, flg;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_pc;
  bit m_dir, m_upd, m_prev_ug;
  bit [3:0] m_flg;

  always #5 clk = ~clk;

  ca_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ug_i(ug), .psc_i(psc), .arr_i(arr),
    .mode_i(mode), .cmp_i(cmp), .trg_sel_i(tsel), .cnt_o(cnt), .dir_o(dir),
    .upd_o(upd), .oc_ref_o(ref_v), .cmp_flag_o(flg), .trg_o(trg)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pc = 0; m_dir = 0; m_upd = 0; m_flg = 0; m_prev_ug = 0;
    end else begin
      int nc; bit nd, wr, ok;
      m_upd = 0; m_flg = 0; m_prev_ug = ug;
      if (ug) begin
        m_cnt = 0; m_pc = 0; m_dir = (mode == 1); m_upd = 1;
      end else if (en) begin
        if (m_pc >= int'(psc)) begin
          m_pc = 0;
          wr = 0;
          if (mode == 1) begin
            nd = 1;
            if (m_cnt == 0) begin nc = int'(arr); wr = 1; end else nc = m_cnt - 1;
          end else if (mode >= 2 && mode <= 4) begin
            if (!m_dir) begin
              if (m_cnt >= int'(arr)) begin nd = 1; nc = (arr == 0) ? 0 : int'(arr) - 1; wr = 1; end
              else begin nd = 0; nc = m_cnt + 1; end
            end else begin
              if (m_cnt == 0) begin nd = 0; nc = (arr == 0) ? 0 : 1; wr = 1; end
              else begin nd = 1; nc = m_cnt - 1; end
            end
          end else begin
            nd = 0;
            if (m_cnt >= int'(arr)) begin nc = 0; wr = 1; end else nc = m_cnt + 1;
          end
          ok = (mode == 2) ? nd : (mode == 3) ? !nd : 1'b1;
          for (int k = 0; k < 4; k++) m_flg[k] = ok && (nc == int'(cmp[k]));
          m_cnt = nc; m_dir = nd; m_upd = wr;
        end else m_pc = m_pc + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic string mtag();
    return (mode == 1) ? "R4" : (mode >= 2 && mode <= 4) ? "R5" : "R3";
  endfunction

  function automatic string ftag();
    return (mode == 2) ? "R6" : (mode == 3) ? "R7" : "R8";
  endfunction

  task automatic compare_all();
    bit [3:0] eref; bit etrg;
    for (int k = 0; k < 4; k++) eref[k] = m_cnt < int'(cmp[k]);
    case (tsel)
      3'd0: etrg = ug;
      3'd1: etrg = en;
      3'd2: etrg = m_upd;
      3'd3: etrg = m_flg[0];
      default: etrg = eref[tsel - 3'd4];
    endcase
    chk(int'(cnt) == m_cnt, m_prev_ug ? "R11 cnt" : {mtag(), " cnt"}, cnt, m_cnt);
    chk(dir == m_dir, {mtag(), " dir"}, dir, m_dir);
    chk(upd == m_upd, m_prev_ug ? "R11 upd" : {mtag(), " upd"}, upd, m_upd);
    chk(flg == m_flg, {ftag(), " flags"}, flg, m_flg);
    chk(ref_v == eref, "R9 oc_ref", ref_v, eref);
    chk(trg == etrg, "R10 trg", trg, etrg);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      compare_all();
      tsel = tsel + 3'd1;
    end
  endtask

  task automatic pulse_ug();
    ug = 1; step(); ug = 0;
  endtask

  task automatic run_mode(input bit [2:0] md, input int n, input int ug_every);
    mode = md; pulse_ug();
    for (int i = 0; i < n; i++) begin
      if (ug_every > 0 && (i % ug_every) == ug_every - 1) ug = 1;
      en = ((i % 11) != 7);
      step();
      ug = 0;
    end
    en = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cmp[0] = 16'd2; cmp[1] = 16'd0; cmp[2] = 16'd5; cmp[3] = 16'd9;
    arr = 16'd5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cnt == 0, "R1 cnt", cnt, 0);
    chk(dir == 0, "R1 dir", dir, 0);
    chk(upd == 0, "R1 upd", upd, 0);
    chk(flg == 0, "R1 flags", flg, 0);
    rst_n = 1;
    step();
    en = 1;
    step(20);
    chk(cnt != 0 || upd, "R1 up after reset", cnt, 1);

    // R2 divide by 3, then hold
    arr = 16'd100; psc = 16'd2; pulse_ug();
    step(9);
    chk(cnt == 3, "R2 divided count", cnt, 3);
    en = 0; step(5);
    chk(cnt == 3, "R2 hold while disabled", cnt, 3);
    en = 1;

    // R11 strobe mid-count
    step(4); pulse_ug();
    chk(cnt == 0 && upd, "R11 strobe clears", cnt, 0);

    arr = 16'd5; psc = 16'd0;
    run_mode(3'd0, 40, 0);
    run_mode(3'd1, 40, 0);
    arr = 16'd6;
    cmp[0] = 16'd3; cmp[1] = 16'd6; cmp[2] = 16'd0; cmp[3] = 16'd1;
    run_mode(3'd2, 60, 0);
    run_mode(3'd3, 60, 0);
    run_mode(3'd4, 60, 0);
    psc = 16'd1;
    for (int md = 0; md < 8; md++) run_mode(3'(md), 80, 5 + md);
    psc = 16'd2;
    for (int md = 0; md < 5; md++) run_mode(3'(md), 90, 7);
    arr = 16'd0; psc = 16'd0;
    cmp[0] = 16'd0;
    for (int md = 0; md < 5; md++) run_mode(3'(md), 20, 0);
    arr = 16'd9; cmp[0] = 16'd9; cmp[1] = 16'd4;
    run_mode(3'd4, 50, 0);
    arr = 16'd3;  // lower than a running count
    step(20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule